// File: doc/BRIEF.md
# Auto-Stepping Index Pointer Pair

This block keeps two 24-bit index pointers, X and Y, that address a flat 16 MB space with no banking. Either pointer can be written from a load port. Either can also be presented as the effective address of a register-indirect memory access. A two-bit index width field limits both pointers to 8, 16 or 24 bits. A second two-bit field gives the size of the memory access, from 1 to 4 bytes. Both fields keep their setting until the surrounding core changes them.

Four status-word control bits make a pointer step on its own after each indirect access through it. The step size is the access size, and the direction bit chooses up or down. The stepped value wraps inside the current index width. The address is produced combinationally in the cycle of the access, and the step takes effect at the clock edge that ends that cycle.

The load port and the access strobe are plain single-cycle strobes. The block accepts one load and one access in every cycle and never applies back-pressure, so there is no ready signal.

Top module: `ptr_index_unit`

## Requirements
- R1: After reset (rst_n low), both x_val and y_val read 0.
- R2: A cycle with ld_en high writes ld_data into the pointer chosen by ld_sel (0 = X, 1 = Y). The value is truncated to the index width and zero-extended, and it is visible on x_val/y_val after that clock edge.
- R3: idx_width codes are 00 = 8 bits, 01 = 16 bits and 10 = 24 bits. Code 11 is not a legal index width and behaves as 24 bits. x_val, y_val and addr are always zero above the current index width.
- R4: While acc_strobe is high, addr equals the current value of the pointer chosen by acc_sel (0 = X, 1 = Y), in the same cycle and without a register in the path.
- R5: The step amount is the acc_width code plus one, in bytes: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4.
- R6: An access through X steps X when stat_hi[3] is set (status bit 19), and an access through Y steps Y when stat_hi[2] is set (status bit 18). The direction bits are stat_hi[1] for X (bit 17) and stat_hi[0] for Y (bit 16), where 0 means increment and 1 means decrement. The stepped value is visible after the access cycle's clock edge.
- R7: A step wraps within the current index width. Incrementing past the top of the width and decrementing below 0 both wrap modulo 2^width.
- R8: An access through a pointer whose enable bit is clear leaves that pointer unchanged.
- R9: An access through one pointer never changes the other pointer.
- R10: If a load and a stepping access hit the same pointer in the same cycle, the loaded value wins. A load to one pointer and a step of the other in the same cycle both take effect.
- R11: In a cycle with no load and no access, both pointers hold their values, including when acc_width changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_width | input | 2 | Index width code (00/01/10, 11 treated as 24-bit) |
| acc_width | input | 2 | Access size code, step = code + 1 bytes |
| stat_hi | input | 4 | Status bits 19..16: X step enable, Y step enable, X direction, Y direction |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 1 | Load target, 0 = X, 1 = Y |
| ld_data | input | 24 | Load value |
| acc_strobe | input | 1 | Indirect access strobe |
| acc_sel | input | 1 | Access pointer, 0 = X, 1 = Y |
| addr | output | 24 | Effective address of the current access |
| x_val | output | 24 | Current X value at the index width |
| y_val | output | 24 | Current Y value at the index width |

## Verification
The bench sweeps every index width, every access size and all sixteen combinations of enable and direction bits. In each combination it starts X just below the top of the width and Y just above zero, so that every step size meets the wrap in both directions. A design that wrapped at 24 bits regardless of width, or that used the raw width code as the step amount, would show wrong pointer values there. The bench also applies a load and an access in the same cycle, to the same pointer and to different pointers: a design that gave stepping priority over the load, or that let a step leak into the idle pointer, fails those checks. Code 11 on the index width is tried directly to catch a design that masks it to some narrower width.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {
    WID_8  = 2'b00,
    WID_16 = 2'b01,
    WID_24 = 2'b10,
    WID_32 = 2'b11
  } width_e;
endpackage

// File: rtl/ptr_width_dec.sv
module ptr_width_dec
  import ptr_pkg::*;
#(
  parameter int AW = 24,
  parameter int SW = 3
) (
  input  width_e        idx_w,
  input  width_e        acc_w,
  output logic [AW-1:0] mask,
  output logic [SW-1:0] step
);
  localparam logic [AW-1:0] FULL = '1;

  always_comb begin
    case (idx_w)
      WID_8:   mask = FULL >> (AW - 8);
      WID_16:  mask = FULL >> (AW - 16);
      default: mask = FULL;
    endcase
  end

  assign step = SW'(acc_w) + SW'(1);
endmodule

// File: rtl/ptr_reg.sv
module ptr_reg #(
  parameter int AW = 24,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_data,
  input  logic          step_go,
  input  logic          step_dn,
  input  logic [SW-1:0] step_amt,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] q
);
  logic [AW-1:0] r;
  logic [AW-1:0] nxt;
  logic [AW-1:0] amt_ext;
  logic [AW:0]   sum_ext;

  assign q       = r & mask;
  assign amt_ext = AW'(step_amt);
  assign sum_ext = {1'b0, q} + {1'b0, amt_ext};

  always_comb begin
    if (ld)
      nxt = ld_data & mask;
    else if (step_go)
      nxt = (step_dn ? (q - amt_ext) : (q + amt_ext)) & mask;
    else
      nxt = r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) r <= '0;
    else        r <= nxt;
  end

  // R2
  load_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (r & ~$past(mask)) == '0);

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !ld && !step_dn && sum_ext <= {1'b0, mask})
      |=> (r - $past(q)) == $past(amt_ext));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !step_go) |=> $stable(r));
endmodule

// File: rtl/ptr_index_unit.sv
module ptr_index_unit
  import ptr_pkg::*;
#(
  parameter int AW = 24,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    idx_width,
  input  logic [1:0]    acc_width,
  input  logic [3:0]    stat_hi,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_strobe,
  input  logic          acc_sel,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] x_val,
  output logic [AW-1:0] y_val
);
  localparam int NPTR = 2;

  logic [AW-1:0] mask;
  logic [SW-1:0] step;
  logic [AW-1:0] vis [NPTR];

  ptr_width_dec #(.AW(AW), .SW(SW)) u_dec (
    .idx_w (width_e'(idx_width)),
    .acc_w (width_e'(acc_width)),
    .mask  (mask),
    .step  (step)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    localparam logic SEL = 1'(i);
    logic ld_i;
    logic go_i;
    assign ld_i = ld_en && (ld_sel == SEL);
    assign go_i = acc_strobe && (acc_sel == SEL) && stat_hi[3-i];

    ptr_reg #(.AW(AW), .SW(SW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld_i),
      .ld_data  (ld_data),
      .step_go  (go_i),
      .step_dn  (stat_hi[1-i]),
      .step_amt (step),
      .mask     (mask),
      .q        (vis[i])
    );
  end

  assign x_val = vis[0];
  assign y_val = vis[1];
  assign addr  = acc_sel ? vis[1] : vis[0];

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr & ~mask) == '0);

  // R9
  x_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && acc_sel && !(ld_en && !ld_sel))
      |=> (x_val == $past(x_val)) || (idx_width != $past(idx_width)));

  // R9
  y_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && !acc_sel && !(ld_en && ld_sel))
      |=> (y_val == $past(y_val)) || (idx_width != $past(idx_width)));
endmodule

// File: tb/ptr_index_unit_test.sv
`timescale 1ns/1ps
module ptr_index_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  iw = 2'd2;
  logic [1:0]  aw = 2'd0;
  logic [3:0]  stat = 4'd0;
  logic        ld_en = 1'b0;
  logic        ld_sel = 1'b0;
  logic [23:0] ld_data = 24'd0;
  logic        acc_strobe = 1'b0;
  logic        acc_sel = 1'b0;
  logic [23:0] addr, x_val, y_val;

  int errs = 0;
  int total = 0;
  logic [23:0] mx = 24'd0;
  logic [23:0] my = 24'd0;

  always #2.5 clk = ~clk;

  ptr_index_unit uut (
    .clk(clk), .rst_n(rst_n), .idx_width(iw), .acc_width(aw), .stat_hi(stat),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .acc_strobe(acc_strobe), .acc_sel(acc_sel),
    .addr(addr), .x_val(x_val), .y_val(y_val)
  );

  function automatic logic [23:0] mk(input logic [1:0] w);
    case (w)
      2'd0:    return 24'h0000FF;
      2'd1:    return 24'h00FFFF;
      default: return 24'hFFFFFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [23:0] a, input logic [23:0] e);
    total++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic cyc(input string tag, input logic l, input logic ls,
                     input logic [23:0] d, input logic a, input logic as);
    logic [23:0] m, vx, vy, nx, ny, st;
    @(negedge clk);
    ld_en = l; ld_sel = ls; ld_data = d; acc_strobe = a; acc_sel = as;
    #1;
    m  = mk(iw);
    st = 24'(aw) + 24'd1;
    vx = mx & m;
    vy = my & m;
    if (a) chk({"R4 addr ", tag}, addr, as ? vy : vx);
    nx = mx; ny = my;
    if (a && !as && stat[3]) nx = (stat[1] ? vx - st : vx + st) & m;
    if (a &&  as && stat[2]) ny = (stat[0] ? vy - st : vy + st) & m;
    if (l && !ls) nx = d & m;
    if (l &&  ls) ny = d & m;
    mx = nx; my = ny;
    @(posedge clk);
    #1;
    ld_en = 1'b0; acc_strobe = 1'b0;
    chk({"x ", tag}, x_val, mx & m);
    chk({"y ", tag}, y_val, my & m);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset x", x_val, 24'd0);
    chk("R1 reset y", y_val, 24'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: width truncation per code, 11 acts as 24-bit
    stat = 4'd0;
    for (int w = 0; w < 4; w++) begin
      iw = 2'(w);
      cyc("R2 R3 load", 1'b1, 1'b0, 24'hABCDEF, 1'b0, 1'b0);
      chk("R3 width", x_val, (w == 0) ? 24'h0000EF : (w == 1) ? 24'h00CDEF : 24'hABCDEF);
    end

    // R5: step amount per access code
    iw = 2'd2; stat = 4'b1000;
    for (int a = 0; a < 4; a++) begin
      aw = 2'(a);
      cyc("R2 load", 1'b1, 1'b0, 24'h000100, 1'b0, 1'b0);
      cyc("R5 step", 1'b0, 1'b0, 24'd0, 1'b1, 1'b0);
      chk("R5 amount", x_val, 24'h000100 + 24'(a + 1));
    end

    // R7: explicit wrap at 8 bits up and at 16 bits down
    iw = 2'd0; aw = 2'd3; stat = 4'b1100;
    cyc("R2 load", 1'b1, 1'b0, 24'h0000FE, 1'b0, 1'b0);
    cyc("R7 wrap", 1'b0, 1'b0, 24'd0, 1'b1, 1'b0);
    chk("R7 wrap up", x_val, 24'h000002);
    iw = 2'd1; stat = 4'b1101;
    cyc("R2 load", 1'b1, 1'b1, 24'h000001, 1'b0, 1'b0);
    cyc("R7 wrap", 1'b0, 1'b0, 24'd0, 1'b1, 1'b1);
    chk("R7 wrap down", y_val, 24'h00FFFD);

    // Sweep all widths, sizes and control patterns
    for (int w = 0; w < 4; w++) begin
      for (int a = 0; a < 4; a++) begin
        for (int s = 0; s < 16; s++) begin
          iw = 2'(w); aw = 2'(a); stat = 4'(s);
          cyc("R2 load", 1'b1, 1'b0, mk(2'(w)) - 24'd1, 1'b0, 1'b0);
          cyc("R2 load", 1'b1, 1'b1, 24'h000001, 1'b0, 1'b0);
          for (int k = 0; k < 3; k++)
            cyc("R6 R7 R8 R9 access", 1'b0, 1'b0, 24'd0, 1'b1, 1'b0);
          for (int k = 0; k < 3; k++)
            cyc("R6 R7 R8 R9 access", 1'b0, 1'b0, 24'd0, 1'b1, 1'b1);
        end
      end
    end

    // R10: load wins over step on the same pointer
    iw = 2'd2; aw = 2'd1; stat = 4'b1100;
    cyc("R2 load", 1'b1, 1'b0, 24'h000040, 1'b0, 1'b0);
    cyc("R10 same", 1'b1, 1'b0, 24'h000005, 1'b1, 1'b0);
    chk("R10 load wins", x_val, 24'h000005);
    // R10: load of Y while X steps
    cyc("R10 split", 1'b1, 1'b1, 24'h000777, 1'b1, 1'b0);
    chk("R10 x stepped", x_val, 24'h000007);
    chk("R10 y loaded", y_val, 24'h000777);

    // R11: idle cycles with a changing access size
    for (int a = 0; a < 4; a++) begin
      aw = 2'(a);
      cyc("R11 idle", 1'b0, 1'b0, 24'h123456, 1'b0, 1'b0);
    end
    chk("R11 x held", x_val, 24'h000007);
    chk("R11 y held", y_val, 24'h000777);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule